// File: doc/BRIEF.md
# Condition-Field Mask/Mode Logic Unit

This unit executes a family of operations that move and combine 4-bit condition fields with integer data and with each other. Its inputs are a 32-bit condition register of eight fields, a 64-bit integer operand, the selector bits of the instruction, a 4-bit mask, a 4-bit mode, an M flag, and the field, bit and register indices. Every variant starts from four per-bit terms, each equal to the mask bit ANDed with "mode bit equals source bit". These terms are then used in one of four ways:

- reduced to one bit by OR or AND;
- packed as a nibble into the integer result;
- merged into a destination field, with M choosing whether the bits the mask leaves out are kept or cleared;
- written into a single addressed condition bit.

A masked-move variant also exists. It copies the masked source field, optionally merges in the old destination bits, and then inverts the bits selected by the mode.

Field k occupies condition-register bits [4k+3:4k], and field bit i is register bit 4k+i. Results are registered, so the outputs show the operation presented one cycle earlier. A synchronous active-high reset clears all outputs. The unit is a drop-in execute stage, and register-file reads and writes are handled around it.

Top module: `cfl_unit`

## Requirements
- R1: Decode. With sel_dir=1: sel_hi=00 gives field-to-integer bit and sel_hi=01 gives field-to-integer nibble. With sel_dir=0: sel_hi=00 gives integer-to-field per bit, sel_hi=01 gives integer-LSB-to-field when sel_b31=0 and single-bit target when sel_b31=1, and sel_hi=11 gives field-to-field when sel_sub=0 and masked move when sel_sub=1. Every other combination changes nothing: cr_res equals cr_in, int_wr=0 and int_res=0.
- R2: Term i (i=0..3) equals mask[i] AND NOT(mode[i] XOR src[i]).
- R3: The field-to-integer bit variant uses field src_fld as the source. It writes the OR of the terms when m_flag=1, or the AND of the terms when m_flag=0, into int_res[0], and sets int_wr=1.
- R4: The field-to-integer nibble variant writes term i into int_res[i] and sets int_wr=1.
- R5: The integer-to-field per-bit variant pairs field bit i with int_in[i].
- R6: The integer-LSB-to-field variant compares every mode bit with int_in[0]. When int_idx is 0, the value 0 is used instead.
- R7: For the per-bit, LSB and field-to-field variants, field dst_fld receives the terms. When m_flag=1, each old bit whose mask bit is 0 is also ORed in; when m_flag=0, those bits are 0. All other fields are unchanged.
- R8: The masked move writes ((mask AND src field) OR (m_flag ? old dst AND NOT mask : 0)) XOR mode into dst_fld.
- R9: The single-bit target writes the R3 reduction into condition-register bit 4*bit_addr[2:0]+bit_addr[4:3]. All other bits are unchanged.
- R10: With sel_b31=1 on an integer variant, field 0 becomes {lt,gt,eq,0} (bit 3 down to bit 0) from a signed compare of the 64-bit result against zero.
- R11: During reset, int_res, int_wr and cr_res are 0 whatever the inputs are. After reset, the outputs follow the inputs with one cycle of latency.
- R12: int_wr is 1 only for the two integer variants. int_res bits above those written are 0, and int_res is 0 when int_wr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_hi | input | 2 | Major selector bits |
| sel_dir | input | 1 | Direction bit: 1 selects integer-writing forms |
| sel_sub | input | 1 | Splits field-to-field from masked move |
| sel_b31 | input | 1 | Record bit, or split of the sel_hi=01 field forms |
| fld_mask | input | 4 | Per-bit mask |
| fld_mode | input | 4 | Per-bit mode |
| m_flag | input | 1 | OR/AND choice and merge enable |
| src_fld | input | 3 | Source field index |
| dst_fld | input | 3 | Destination field index |
| bit_addr | input | 5 | Single-bit target address |
| int_idx | input | 5 | Integer register index (0 means constant zero) |
| int_in | input | 64 | Integer operand |
| cr_in | input | 32 | Current condition register |
| int_res | output | 64 | Integer result |
| int_wr | output | 1 | Integer result valid |
| cr_res | output | 32 | Updated condition register |

## Verification
The hardest situation to reach is a field merge in which the destination field is also the source field, or a single-bit target that lands in field 0 while other fields hold distinct data. Either one hides errors in the field and bit indexing unless the indices move against each other. The sweep covers every selector encoding, all 256 mask/mode pairs and both M values, and it rotates the source, destination and bit address with the mask and mode so that these overlaps recur. It also changes the condition-register contents per vector, so that kept bits and overwritten bits can be told apart.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_F2I_BIT,
    OP_F2I_NIB,
    OP_I2F_BITS,
    OP_I2F_LSB,
    OP_F2BIT,
    OP_F2F,
    OP_FMOVE
  } cfl_op_e;
endpackage

// File: rtl/cfl_decode.sv
module cfl_decode
  import cfl_pkg::*;
(
  input  logic [1:0] sel_hi,
  input  logic       sel_dir,
  input  logic       sel_sub,
  input  logic       sel_b31,
  output cfl_op_e    op,
  output logic       rc_en
);
  always_comb begin
    op    = OP_NONE;
    rc_en = 1'b0;
    if (sel_dir) begin
      if (sel_hi == 2'b00)      op = OP_F2I_BIT;
      else if (sel_hi == 2'b01) op = OP_F2I_NIB;
      rc_en = sel_b31 && (sel_hi[1] == 1'b0);
    end else begin
      case (sel_hi)
        2'b00:   op = OP_I2F_BITS;
        2'b01:   op = sel_b31 ? OP_F2BIT : OP_I2F_LSB;
        2'b11:   op = sel_sub ? OP_FMOVE : OP_F2F;
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cfl_terms.sv
module cfl_terms #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] src,
  input  logic [FW-1:0] mask,
  input  logic [FW-1:0] mode,
  input  logic          m_or,
  output logic [FW-1:0] terms,
  output logic          red
);
  for (genvar i = 0; i < FW; i++) begin : g_term
    assign terms[i] = mask[i] & ~(mode[i] ^ src[i]);
  end
  assign red = m_or ? (|terms) : (&terms);
endmodule

// File: rtl/cfl_field_write.sv
module cfl_field_write #(
  parameter int NFIELD = 8,
  parameter int FW     = 4,
  localparam int CRW   = NFIELD * FW,
  localparam int FIW   = $clog2(NFIELD)
) (
  input  logic [CRW-1:0] cr_in,
  input  logic [FIW-1:0] dst,
  input  logic [FW-1:0]  new_fld,
  input  logic           en,
  output logic [CRW-1:0] cr_out
);
  for (genvar k = 0; k < NFIELD; k++) begin : g_fld
    assign cr_out[k*FW +: FW] = (en && (dst == FIW'(k))) ? new_fld : cr_in[k*FW +: FW];
  end
endmodule

// File: rtl/cfl_unit.sv
module cfl_unit
  import cfl_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NFIELD = 8,
  parameter int FW     = 4,
  parameter int RIW    = 5,
  localparam int CRW   = NFIELD * FW,
  localparam int FIW   = $clog2(NFIELD),
  localparam int BIW   = $clog2(FW),
  localparam int BAW   = FIW + BIW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      sel_hi,
  input  logic            sel_dir,
  input  logic            sel_sub,
  input  logic            sel_b31,
  input  logic [FW-1:0]   fld_mask,
  input  logic [FW-1:0]   fld_mode,
  input  logic            m_flag,
  input  logic [FIW-1:0]  src_fld,
  input  logic [FIW-1:0]  dst_fld,
  input  logic [BAW-1:0]  bit_addr,
  input  logic [RIW-1:0]  int_idx,
  input  logic [XLEN-1:0] int_in,
  input  logic [CRW-1:0]  cr_in,
  output logic [XLEN-1:0] int_res,
  output logic            int_wr,
  output logic [CRW-1:0]  cr_res
);
  cfl_op_e        op;
  logic           rc_en;
  logic [FW-1:0]  src_val, old_dst, term_src, terms, keep, fld_new;
  logic           red, lsb, fld_en, int_en;
  logic           lt, gt, eq;
  logic [FW-1:0]  flags;
  logic [BAW-1:0] bit_pos;
  logic [CRW-1:0] cr_s1, cr_s2, cr_nxt, dst_span;
  logic [XLEN-1:0] int_nxt;
  logic           unused_hi;

  assign unused_hi = ^int_in[XLEN-1:FW];

  cfl_decode u_dec (
    .sel_hi (sel_hi),
    .sel_dir(sel_dir),
    .sel_sub(sel_sub),
    .sel_b31(sel_b31),
    .op     (op),
    .rc_en  (rc_en)
  );

  assign src_val = cr_in[src_fld*FW +: FW];
  assign old_dst = cr_in[dst_fld*FW +: FW];
  assign lsb     = (int_idx == '0) ? 1'b0 : int_in[0];

  always_comb begin
    case (op)
      OP_I2F_BITS: term_src = int_in[FW-1:0];
      OP_I2F_LSB:  term_src = {FW{lsb}};
      default:     term_src = src_val;
    endcase
  end

  cfl_terms #(.FW(FW)) u_terms (
    .src  (term_src),
    .mask (fld_mask),
    .mode (fld_mode),
    .m_or (m_flag),
    .terms(terms),
    .red  (red)
  );

  assign keep    = m_flag ? (old_dst & ~fld_mask) : '0;
  assign fld_new = (op == OP_FMOVE) ? (((fld_mask & src_val) | keep) ^ fld_mode)
                                    : (terms | keep);
  assign fld_en  = (op == OP_I2F_BITS) || (op == OP_I2F_LSB) ||
                   (op == OP_F2F) || (op == OP_FMOVE);
  assign int_en  = (op == OP_F2I_BIT) || (op == OP_F2I_NIB);

  cfl_field_write #(.NFIELD(NFIELD), .FW(FW)) u_fw_dst (
    .cr_in  (cr_in),
    .dst    (dst_fld),
    .new_fld(fld_new),
    .en     (fld_en),
    .cr_out (cr_s1)
  );

  // field index in the upper address bits of the flat position, bit-in-field below
  assign bit_pos = {bit_addr[FIW-1:0], bit_addr[BAW-1:FIW]};

  always_comb begin
    cr_s2 = cr_s1;
    if (op == OP_F2BIT) cr_s2[bit_pos] = red;
  end

  always_comb begin
    int_nxt = '0;
    if (op == OP_F2I_BIT)      int_nxt[0]      = red;
    else if (op == OP_F2I_NIB) int_nxt[FW-1:0] = terms;
  end

  assign lt = int_nxt[XLEN-1];
  assign eq = (int_nxt == '0);
  assign gt = !lt && !eq;

  always_comb begin
    flags       = '0;
    flags[FW-1] = lt;
    flags[FW-2] = gt;
    flags[FW-3] = eq;
  end

  cfl_field_write #(.NFIELD(NFIELD), .FW(FW)) u_fw_rc (
    .cr_in  (cr_s2),
    .dst    ('0),
    .new_fld(flags),
    .en     (rc_en),
    .cr_out (cr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_res <= '0;
      int_wr  <= 1'b0;
      cr_res  <= '0;
    end else begin
      int_res <= int_nxt;
      int_wr  <= int_en;
      cr_res  <= cr_nxt;
    end
  end

  assign dst_span = {{(CRW-FW){1'b0}}, {FW{1'b1}}} << (dst_fld * FW);

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NONE) |=> (cr_res == $past(cr_in)) && !int_wr); // R1
  AST_FIELD_OTHERS_KEEP: assert property (@(posedge clk) disable iff (rst)
    fld_en |=> (((cr_res ^ $past(cr_in)) & ~$past(dst_span)) == '0)); // R7
  AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (op == OP_F2BIT) |=> ($countones(cr_res ^ $past(cr_in)) <= 1)); // R9
  AST_RC_EQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    rc_en |=> (cr_res[FW-3] == (int_res == '0))); // R10
  AST_FIELD_NO_INT: assert property (@(posedge clk) disable iff (rst)
    fld_en |=> !int_wr && (int_res == '0)); // R12
  AST_INT_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    int_wr |-> ((int_res >> FW) == '0)); // R12
endmodule

// File: tb/cfl_unit_tb.sv
`timescale 1ns/1ps
module cfl_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  sel_hi;
  logic        sel_dir, sel_sub, sel_b31;
  logic [3:0]  fld_mask, fld_mode;
  logic        m_flag;
  logic [2:0]  src_fld, dst_fld;
  logic [4:0]  bit_addr, int_idx;
  logic [63:0] int_in;
  logic [31:0] cr_in;
  logic [63:0] int_res;
  logic        int_wr;
  logic [31:0] cr_res;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfl_unit u_dut (
    .clk(clk), .rst(rst), .sel_hi(sel_hi), .sel_dir(sel_dir), .sel_sub(sel_sub),
    .sel_b31(sel_b31), .fld_mask(fld_mask), .fld_mode(fld_mode), .m_flag(m_flag),
    .src_fld(src_fld), .dst_fld(dst_fld), .bit_addr(bit_addr), .int_idx(int_idx),
    .int_in(int_in), .cr_in(cr_in), .int_res(int_res), .int_wr(int_wr), .cr_res(cr_res)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference model: k selects the variant (0..6), 7 and 8 are unused encodings
  function automatic void model(
    input int k, input logic [3:0] mk, input logic [3:0] md, input logic mf, input logic rc,
    input logic [31:0] cr, input logic [63:0] iv, input logic [2:0] sf, input logic [2:0] df,
    input logic [4:0] ba, input logic [4:0] idx,
    output logic [63:0] ei, output logic ew, output logic [31:0] ec);
    logic [3:0] s, n, old, nf;
    logic r;
    int pos;
    ei = 64'd0; ew = 1'b0; ec = cr;
    old = cr[df*4 +: 4];
    case (k)
      2:       s = iv[3:0];
      3:       s = (idx == 5'd0) ? 4'h0 : {4{iv[0]}};
      default: s = cr[sf*4 +: 4];
    endcase
    for (int i = 0; i < 4; i++) n[i] = mk[i] && (md[i] == s[i]);
    r = mf ? (n != 4'h0) : (n == 4'hF);
    case (k)
      0: begin ei[0] = r; ew = 1'b1; end
      1: begin ei[3:0] = n; ew = 1'b1; end
      2, 3, 5: begin
        nf = n;
        if (mf) nf = nf | (old & ~mk);
        ec[df*4 +: 4] = nf;
      end
      4: begin pos = ba[2:0] * 4 + ba[4:3]; ec[pos] = r; end
      6: begin
        nf = mk & cr[sf*4 +: 4];
        if (mf) nf = nf | (old & ~mk);
        ec[df*4 +: 4] = nf ^ md;
      end
      default: ;
    endcase
    if (rc && (k == 0 || k == 1))
      ec[3:0] = {ei[63], (ei[63] == 1'b0) && (ei != 0), ei == 0, 1'b0};
  endfunction

  task automatic drive(input int k, input int p, input logic rc);
    sel_sub = p[0];
    sel_b31 = p[1];
    case (k)
      0: begin sel_hi = 2'b00; sel_dir = 1'b1; sel_b31 = rc; end
      1: begin sel_hi = 2'b01; sel_dir = 1'b1; sel_b31 = rc; end
      2: begin sel_hi = 2'b00; sel_dir = 1'b0; end
      3: begin sel_hi = 2'b01; sel_dir = 1'b0; sel_b31 = 1'b0; end
      4: begin sel_hi = 2'b01; sel_dir = 1'b0; sel_b31 = 1'b1; end
      5: begin sel_hi = 2'b11; sel_dir = 1'b0; sel_sub = 1'b0; end
      6: begin sel_hi = 2'b11; sel_dir = 1'b0; sel_sub = 1'b1; end
      7: begin sel_hi = 2'b10; sel_dir = p[0]; end
      default: begin sel_hi = 2'b11; sel_dir = 1'b1; sel_b31 = 1'b1; end
    endcase
  endtask

  task automatic pseudo(input string tag, input logic [3:0] mk, input logic [3:0] md,
                        input logic mf, input logic [3:0] exp_fld);
    @(negedge clk);
    drive(3, 0, 1'b0);
    fld_mask = mk; fld_mode = md; m_flag = mf;
    int_idx = 5'd0; int_in = 64'hFFFF_FFFF_FFFF_FFFF;
    cr_in = 32'h5A5A_5A5A; dst_fld = 3'd2;
    @(negedge clk);
    check(tag, {32'h0, cr_res}, {32'h0, (32'h5A5A_5A5A & ~32'h0000_0F00) | (32'(exp_fld) << 8)});
  endtask

  initial begin
    logic [63:0] ei;
    logic        ew;
    logic [31:0] ec;
    rst = 1'b1;
    drive(1, 0, 1'b1);
    fld_mask = 4'hF; fld_mode = 4'h0; m_flag = 1'b1;
    src_fld = 3'd1; dst_fld = 3'd3; bit_addr = 5'd7; int_idx = 5'd4;
    int_in = 64'h0123_4567_89AB_CDEF; cr_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R11 reset int_res", int_res, 64'd0);
    check("R11 reset int_wr", {63'd0, int_wr}, 64'd0);
    check("R11 reset cr_res", {32'd0, cr_res}, 64'd0);
    rst = 1'b0;

    // set / clear / immediate-load forms through the LSB variant with index 0
    pseudo("R6 set bits", 4'b0101, 4'b0000, 1'b1, 4'b1010 | 4'b0101);
    pseudo("R6 clear bits", 4'b1010, 4'b1111, 1'b1, 4'b1010 & ~4'b1010);
    pseudo("R6 load immediate", 4'b1111, ~4'b0110, 1'b0, 4'b0110);

    for (int k = 0; k < 9; k++) begin
      for (int v = 0; v < 512; v++) begin
        for (int p = 0; p < 3; p++) begin
          logic [3:0] mk, md;
          logic mf, rc;
          string ti, tc;
          mk = v[3:0]; md = v[7:4]; mf = v[8];
          rc = md[0] ^ p[0];
          @(negedge clk);
          drive(k, p, rc);
          fld_mask = mk; fld_mode = md; m_flag = mf;
          cr_in  = 32'h6B1D_94E7 ^ (32'(mk) * 32'h0111_1111) ^ (32'(p + 1) << (md * 2));
          int_in = {32'h8000_0000 * 32'(p[0]), cr_in} ^ (64'(md) * 64'h0001_0001_0001_0001);
          src_fld  = 3'(mk + 4'(p));
          dst_fld  = 3'(md + 4'(p));
          bit_addr = 5'(mk * 3 + md + 4'(p));
          int_idx  = 5'(p);
          model(k, mk, md, mf, rc, cr_in, int_in, src_fld, dst_fld, bit_addr, int_idx, ei, ew, ec);
          case (k)
            0: begin ti = "R3 bit reduce"; tc = "R10 record field"; end
            1: begin ti = "R2 R4 nibble"; tc = "R10 record field"; end
            2: begin ti = "R12 no int"; tc = "R5 R7 per-bit field"; end
            3: begin ti = "R12 no int"; tc = "R6 R7 lsb field"; end
            4: begin ti = "R12 no int"; tc = "R9 single bit"; end
            5: begin ti = "R12 no int"; tc = "R2 R7 field merge"; end
            6: begin ti = "R12 no int"; tc = "R8 masked move"; end
            default: begin ti = "R1 unused int"; tc = "R1 unused cr"; end
          endcase
          @(negedge clk);
          check(ti, int_res, ei);
          check("R12 int_wr", {63'd0, int_wr}, {63'd0, ew});
          check(tc, {32'd0, cr_res}, {32'd0, ec});
        end
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule